// File: doc/BRIEF.md
# Memory Range Zero-Fill Engine

The block clears a span of physical memory on command. Software programs an inclusive start address and an inclusive end address into two registers, then writes an operation code into a command register. When the code selects zero fill, the engine walks the range as a series of bursts, none longer than 4096 bytes. Each burst is issued on a write master that carries 64-bit beats with byte enables, so a range may begin and end on any byte.

Each burst begins on the byte after the previous one ended, and the final burst covers only what remains. A busy flag is high from the accepted command until the memory side acknowledges the final burst. A one-cycle done pulse marks completion. A code other than zero fill, or a range whose end lies below its start, is refused: an error flag is raised and no write is issued. A handful of further offsets, including a 16-entry table, are plain read/write storage with no side effect.

The controller is a four-state machine. `ZF_IDLE` waits for a command. `ZF_REQ` presents a burst request until it is taken. `ZF_DATA` streams the beats of that burst. `ZF_ACK` waits for the burst acknowledge. The transitions are: idle to request on an accepted start; request to data on request handshake; data to ack on the handshake of the last beat; ack to request on acknowledge with range left; ack to idle on acknowledge of the final burst.

Top module: `zfill_engine`

## Requirements
- R1: After reset busy, err and done are 0, no request or beat is valid, and every register reads 0.
- R2: The start address (0x3030), end address (0x3038), command (0x3800), storage words at 0x3008, 0x3018 and 0x4000, and the table entries at 0x1700 + 8*k (k = 0..15) read back the last value written; any other offset reads 0 and ignores writes.
- R3: Writing the 64-bit value 0x11 to 0x3800 while idle, with end >= start, starts a fill; busy reads 1 in the following cycle and err is cleared.
- R4: Writing any other value to 0x3800 while idle sets err, issues no burst and leaves busy at 0; the command register still reads back the written value.
- R5: Both range ends are inclusive: a burst's address is its first byte rounded down to a multiple of 8; its first beat enables byte lanes from start[2:0] up (wr_beat_be bit i is lane i), its last beat enables lanes up to end[2:0], and middle beats enable all 8 lanes.
- R6: Bursts cover the range in order without gaps; each spans at most 4096 bytes, starts one byte past the previous burst's end, and its beat count is (end_byte/8 - start_byte/8 + 1).
- R7: A request holds its address and beat count until accepted; a beat holds its enables until accepted; wr_beat_last marks exactly the final beat of a burst; beat data is all zero.
- R8: busy stays 1 until the acknowledge of the final burst and falls in the next cycle, in which done pulses for exactly one cycle.
- R9: A command write while busy is ignored: no extra burst, err unchanged, and the command register keeps its previous value.
- R10: A zero-fill command with end < start is refused like an unknown code: err is set and no burst is issued.
- R11: err stays set until the next accepted zero-fill start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr (combinational) |
| busy | output | 1 | Fill in progress |
| err | output | 1 | Last command refused |
| done | output | 1 | One-cycle completion pulse |
| wr_req_valid | output | 1 | Burst request valid |
| wr_req_ready | input | 1 | Burst request accepted |
| wr_req_addr | output | 40 | Burst address, 8-byte aligned |
| wr_req_beats | output | 10 | Number of beats in the burst |
| wr_beat_valid | output | 1 | Write beat valid |
| wr_beat_ready | input | 1 | Write beat accepted |
| wr_beat_data | output | 64 | Beat data (zero) |
| wr_beat_be | output | 8 | Byte enables, bit i for byte lane i |
| wr_beat_last | output | 1 | Final beat of the burst |
| wr_ack | input | 1 | Burst write acknowledge |

## Verification
On every cycle the assertions hold the handshake rules: requests and beats never overlap, a stalled request or beat keeps its fields, no beat is accepted past the burst's count, and busy and err do not move on a command that arrives while busy. Done pulses only as busy falls. Burst addresses, beat counts and lane masks across chunk borders, unaligned ends and single-beat ranges can only be shown by the scenarios. So can the absence of any burst after a refused or ignored command, against a scoreboard of bursts computed from the programmed range.

// File: rtl/zf_pkg.sv
`timescale 1ns/1ps
package zf_pkg;
    typedef enum logic [1:0] {
        ZF_IDLE = 2'd0,
        ZF_REQ  = 2'd1,
        ZF_DATA = 2'd2,
        ZF_ACK  = 2'd3
    } zf_state_e;

    localparam int REG_AW = 16;
    localparam int REG_DW = 64;
    localparam logic [REG_AW-1:0] OFS_FIRST = 16'h3030;
    localparam logic [REG_AW-1:0] OFS_LAST  = 16'h3038;
    localparam logic [REG_AW-1:0] OFS_CMD   = 16'h3800;
    localparam logic [REG_AW-1:0] OFS_TBL   = 16'h1700;
    localparam int AUX_N = 3;
    localparam logic [REG_AW-1:0] AUX_OFS [AUX_N] = '{16'h3008, 16'h3018, 16'h4000};
    localparam int TBL_N = 16;
    localparam logic [REG_DW-1:0] OP_ZERO_FILL = 64'h11;
endpackage

// File: rtl/zf_regs.sv
`timescale 1ns/1ps
module zf_regs
    import zf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    output logic [REG_DW-1:0] rdata,
    input  logic              busy,
    output logic [REG_DW-1:0] first_q,
    output logic [REG_DW-1:0] last_q,
    output logic              cmd_wr
);
    localparam int TBL_IW  = $clog2(TBL_N);
    localparam int TBL_LSB = 3 + TBL_IW;

    logic [REG_DW-1:0] cmd_q;
    logic [REG_DW-1:0] aux_q [AUX_N];
    logic [REG_DW-1:0] tbl_q [TBL_N];
    logic              tbl_hit;
    logic [TBL_IW-1:0] tbl_idx;

    assign cmd_wr  = wr_en && (addr == OFS_CMD);
    assign tbl_hit = (addr[REG_AW-1:TBL_LSB] == OFS_TBL[REG_AW-1:TBL_LSB]) && (addr[2:0] == 3'd0);
    assign tbl_idx = addr[TBL_LSB-1:3];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= '0;
            last_q  <= '0;
            cmd_q   <= '0;
        end else begin
            if (wr_en && addr == OFS_FIRST) first_q <= wdata;
            if (wr_en && addr == OFS_LAST)  last_q  <= wdata;
            if (cmd_wr && !busy)            cmd_q   <= wdata;
        end
    end

    for (genvar g = 0; g < AUX_N; g++) begin : g_aux
        always_ff @(posedge clk) begin
            if (!rst_n)                           aux_q[g] <= '0;
            else if (wr_en && addr == AUX_OFS[g]) aux_q[g] <= wdata;
        end
    end

    for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
        always_ff @(posedge clk) begin
            if (!rst_n)                                           tbl_q[g] <= '0;
            else if (wr_en && tbl_hit && tbl_idx == TBL_IW'(g))  tbl_q[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == OFS_FIRST) rdata = first_q;
        if (addr == OFS_LAST)  rdata = last_q;
        if (addr == OFS_CMD)   rdata = cmd_q;
        for (int i = 0; i < AUX_N; i++) begin
            if (addr == AUX_OFS[i]) rdata = aux_q[i];
        end
        if (tbl_hit) rdata = tbl_q[tbl_idx];
    end

    // R9: a command arriving while busy leaves the command register untouched
    a_r9_cmd_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> $stable(cmd_q));
endmodule

// File: rtl/zf_beats.sv
`timescale 1ns/1ps
module zf_beats #(
    parameter int BEAT_BYTES = 8,
    parameter int CNT_W      = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [CNT_W-1:0]              load_beats,
    input  logic [$clog2(BEAT_BYTES)-1:0] load_sl,
    input  logic [$clog2(BEAT_BYTES)-1:0] load_el,
    input  logic                          active,
    input  logic                          advance,
    output logic [BEAT_BYTES-1:0]         be,
    output logic                          is_last
);
    localparam int LANE_W = $clog2(BEAT_BYTES);

    logic [CNT_W-1:0]  idx;
    logic [CNT_W-1:0]  total;
    logic [LANE_W-1:0] sl;
    logic [LANE_W-1:0] el;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            total <= '0;
            sl    <= '0;
            el    <= '0;
        end else if (load) begin
            idx   <= '0;
            total <= load_beats;
            sl    <= load_sl;
            el    <= load_el;
        end else if (advance) begin
            idx <= idx + CNT_W'(1);
        end
    end

    assign is_last = (idx == total - CNT_W'(1));

    for (genvar g = 0; g < BEAT_BYTES; g++) begin : g_lane
        assign be[g] = !((idx == '0) && (LANE_W'(g) < sl)) && !(is_last && (LANE_W'(g) > el));
    end

    // R7: no beat is accepted beyond the count of the current burst
    a_r7_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (idx < total));
    // R7: a stalled beat keeps its byte enables
    a_r7_be_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !advance) |=> $stable(be));
endmodule

// File: rtl/zf_ctrl.sv
`timescale 1ns/1ps
module zf_ctrl
    import zf_pkg::*;
#(
    parameter int ADDR_W      = 40,
    parameter int CHUNK_BYTES = 4096,
    parameter int BEAT_BYTES  = 8,
    parameter int CNT_W       = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_wr,
    input  logic [REG_DW-1:0]             cmd_data,
    input  logic [ADDR_W-1:0]             first_addr,
    input  logic [ADDR_W-1:0]             last_addr,
    input  logic                          req_ready,
    input  logic                          beat_ready,
    input  logic                          beat_is_last,
    input  logic                          wr_ack,
    output logic                          busy,
    output logic                          err,
    output logic                          done,
    output logic                          req_valid,
    output logic                          beat_valid,
    output logic [ADDR_W-1:0]             req_addr,
    output logic [CNT_W-1:0]              req_beats,
    output logic [$clog2(BEAT_BYTES)-1:0] req_sl,
    output logic [$clog2(BEAT_BYTES)-1:0] req_el
);
    localparam int LANE_W = $clog2(BEAT_BYTES);
    localparam logic [ADDR_W-1:0] CHUNK_A = ADDR_W'(CHUNK_BYTES);

    zf_state_e         state, state_n;
    logic [ADDR_W-1:0] cur;
    logic [ADDR_W-1:0] end_l;
    logic [ADDR_W-1:0] rem;
    logic [ADDR_W-1:0] cend;
    logic [ADDR_W-1:0] span;
    logic              fin;
    logic              start;

    assign start = cmd_wr && (cmd_data == OP_ZERO_FILL) && (first_addr <= last_addr);
    assign rem   = end_l - cur;
    assign fin   = rem < CHUNK_A;
    assign cend  = fin ? end_l : (cur + CHUNK_A - ADDR_W'(1));
    assign span  = (cend >> LANE_W) - (cur >> LANE_W);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ZF_IDLE;
        else        state <= state_n;
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ZF_IDLE: if (start)                      state_n = ZF_REQ;
            ZF_REQ:  if (req_ready)                  state_n = ZF_DATA;
            ZF_DATA: if (beat_ready && beat_is_last) state_n = ZF_ACK;
            ZF_ACK:  if (wr_ack)                     state_n = fin ? ZF_IDLE : ZF_REQ;
            default:                                 state_n = ZF_IDLE;
        endcase
    end

    // range pointer, error flag and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur   <= '0;
            end_l <= '0;
            err   <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= (state == ZF_ACK) && wr_ack && fin;
            if (state == ZF_IDLE && cmd_wr) begin
                if (start) begin
                    cur   <= first_addr;
                    end_l <= last_addr;
                    err   <= 1'b0;
                end else begin
                    err <= 1'b1;
                end
            end
            if (state == ZF_ACK && wr_ack && !fin) cur <= cend + ADDR_W'(1);
        end
    end

    // outputs
    always_comb begin
        busy       = 1'b1;
        req_valid  = 1'b0;
        beat_valid = 1'b0;
        unique case (state)
            ZF_IDLE: busy       = 1'b0;
            ZF_REQ:  req_valid  = 1'b1;
            ZF_DATA: beat_valid = 1'b1;
            ZF_ACK:  ;
            default: busy       = 1'b0;
        endcase
        req_addr  = {cur[ADDR_W-1:LANE_W], LANE_W'(0)};
        req_beats = span[CNT_W-1:0] + CNT_W'(1);
        req_sl    = cur[LANE_W-1:0];
        req_el    = cend[LANE_W-1:0];
    end

    // R7: request and beat phases never overlap
    a_r7_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && beat_valid));
    // R7: a stalled request keeps address and count
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_beats)));
    // R6: a burst never exceeds one chunk of beats
    a_r6_beats_range: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_beats != '0 && req_beats <= CNT_W'(CHUNK_BYTES / BEAT_BYTES + 1)));
    // R8: done only as busy falls
    a_r8_done_edge: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R9: a command while busy changes neither busy nor err
    a_r9_busy_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy && !wr_ack) |=> (busy && $stable(err)));
endmodule

// File: rtl/zfill_engine.sv
`timescale 1ns/1ps
module zfill_engine
    import zf_pkg::*;
#(
    parameter int ADDR_W      = 40,
    parameter int CHUNK_BYTES = 4096,
    parameter int BEAT_BYTES  = 8,
    parameter int CNT_W       = $clog2(CHUNK_BYTES / BEAT_BYTES + 2)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr_en,
    input  logic [REG_AW-1:0]       reg_addr,
    input  logic [REG_DW-1:0]       reg_wdata,
    output logic [REG_DW-1:0]       reg_rdata,
    output logic                    busy,
    output logic                    err,
    output logic                    done,
    output logic                    wr_req_valid,
    input  logic                    wr_req_ready,
    output logic [ADDR_W-1:0]       wr_req_addr,
    output logic [CNT_W-1:0]        wr_req_beats,
    output logic                    wr_beat_valid,
    input  logic                    wr_beat_ready,
    output logic [BEAT_BYTES*8-1:0] wr_beat_data,
    output logic [BEAT_BYTES-1:0]   wr_beat_be,
    output logic                    wr_beat_last,
    input  logic                    wr_ack
);
    localparam int LANE_W = $clog2(BEAT_BYTES);

    logic [REG_DW-1:0] first_q, last_q;
    logic              cmd_wr;
    logic [LANE_W-1:0] sl, el;

    zf_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .busy    (busy),
        .first_q (first_q),
        .last_q  (last_q),
        .cmd_wr  (cmd_wr)
    );

    zf_ctrl #(
        .ADDR_W      (ADDR_W),
        .CHUNK_BYTES (CHUNK_BYTES),
        .BEAT_BYTES  (BEAT_BYTES),
        .CNT_W       (CNT_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .cmd_data     (reg_wdata),
        .first_addr   (first_q[ADDR_W-1:0]),
        .last_addr    (last_q[ADDR_W-1:0]),
        .req_ready    (wr_req_ready),
        .beat_ready   (wr_beat_ready),
        .beat_is_last (wr_beat_last),
        .wr_ack       (wr_ack),
        .busy         (busy),
        .err          (err),
        .done         (done),
        .req_valid    (wr_req_valid),
        .beat_valid   (wr_beat_valid),
        .req_addr     (wr_req_addr),
        .req_beats    (wr_req_beats),
        .req_sl       (sl),
        .req_el       (el)
    );

    zf_beats #(
        .BEAT_BYTES (BEAT_BYTES),
        .CNT_W      (CNT_W)
    ) u_beats (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (wr_req_valid && wr_req_ready),
        .load_beats (wr_req_beats),
        .load_sl    (sl),
        .load_el    (el),
        .active     (wr_beat_valid),
        .advance    (wr_beat_valid && wr_beat_ready),
        .be         (wr_beat_be),
        .is_last    (wr_beat_last)
    );

    assign wr_beat_data = '0;
endmodule

// File: tb/zfill_engine_tb_top.sv
`timescale 1ns/1ps
module zfill_engine_tb_top;
    localparam int AW    = 40;
    localparam int CHUNK = 4096;

    typedef struct {
        logic [AW-1:0] addr;
        int            beats;
        int            sl;
        int            el;
    } burst_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        busy, err, done;
    logic        wr_req_valid, wr_beat_valid, wr_beat_last;
    logic        wr_req_ready = 1'b0;
    logic        wr_beat_ready = 1'b0;
    logic        wr_ack = 1'b0;
    logic [AW-1:0] wr_req_addr;
    logic [9:0]  wr_req_beats;
    logic [63:0] wr_beat_data;
    logic [7:0]  wr_beat_be;

    always #2.5 clk = ~clk;

    zfill_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .err(err), .done(done),
        .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
        .wr_req_addr(wr_req_addr), .wr_req_beats(wr_req_beats),
        .wr_beat_valid(wr_beat_valid), .wr_beat_ready(wr_beat_ready),
        .wr_beat_data(wr_beat_data), .wr_beat_be(wr_beat_be),
        .wr_beat_last(wr_beat_last), .wr_ack(wr_ack)
    );

    int     total = 0;
    int     bad = 0;
    int     cycle = 0;
    int     done_cnt = 0;
    bit     finished = 1'b0;
    burst_t exp_q[$];
    burst_t cur_b;
    int     bidx = 0;
    bit     ack_pend = 1'b0;
    int     ack_cnt = 0;
    bit     prev_busy = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // monitor: drives readies and ack, pops expected bursts and compares
    always @(negedge clk) begin
        cycle++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (cycle > 150000) begin
            chk(1'b0, "WD", "watchdog expired", 64'(cycle), 64'd150000);
            finish_run();
        end
        wr_ack = 1'b0;
        if (ack_pend) begin
            if (ack_cnt == 0) begin
                wr_ack   = 1'b1;
                ack_pend = 1'b0;
            end else begin
                ack_cnt--;
            end
        end
        wr_req_ready  = lfsr[0] | lfsr[1];
        wr_beat_ready = lfsr[2] | lfsr[3];
        if (rst_n && wr_req_valid && wr_req_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6", "unexpected burst", 64'(wr_req_addr), 64'd0);
                cur_b.beats = 0;
            end else begin
                cur_b = exp_q.pop_front();
                chk(wr_req_addr == cur_b.addr, "R6", "burst address", 64'(wr_req_addr), 64'(cur_b.addr));
                chk(int'(wr_req_beats) == cur_b.beats, "R6", "burst beats", 64'(wr_req_beats), 64'(cur_b.beats));
            end
            bidx = 0;
        end
        if (rst_n && wr_beat_valid && wr_beat_ready) begin
            logic [7:0] ebe;
            for (int i = 0; i < 8; i++)
                ebe[i] = !((bidx == 0) && (i < cur_b.sl)) && !((bidx == cur_b.beats - 1) && (i > cur_b.el));
            chk(wr_beat_be == ebe, "R5", "byte enables", 64'(wr_beat_be), 64'(ebe));
            chk(wr_beat_last == (bidx == cur_b.beats - 1), "R7", "beat last flag", 64'(wr_beat_last), 64'(bidx == cur_b.beats - 1));
            if (wr_beat_data != '0) chk(1'b0, "R7", "beat data not zero", wr_beat_data, 64'd0);
            if (wr_beat_last) begin
                ack_pend = 1'b1;
                ack_cnt  = int'(lfsr[5:4]);
            end
            bidx++;
        end
        if (rst_n && done) begin
            chk(!busy && prev_busy, "R8", "done with busy falling", {62'd0, busy, prev_busy}, 64'd1);
            done_cnt++;
        end
        prev_busy = busy;
    end

    task automatic reg_wr(input logic [15:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic chk_rd(input logic [15:0] a, input logic [63:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == e, tag, $sformatf("readback @%0h", a), reg_rdata, e);
    endtask

    task automatic push_range(input logic [AW-1:0] f, input logic [AW-1:0] l);
        logic [AW-1:0] c, e;
        burst_t b;
        c = f;
        forever begin
            e = ((l - c) < AW'(CHUNK)) ? l : c + AW'(CHUNK - 1);
            b.addr  = {c[AW-1:3], 3'b000};
            b.beats = int'((e >> 3) - (c >> 3)) + 1;
            b.sl    = int'(c[2:0]);
            b.el    = int'(e[2:0]);
            exp_q.push_back(b);
            if (e == l) break;
            c = e + 1;
        end
    endtask

    task automatic wait_done(input int n);
        while (done_cnt < n) @(negedge clk);
    endtask

    task automatic run_fill(input logic [AW-1:0] f, input logic [AW-1:0] l, input string tag);
        int n;
        n = done_cnt + 1;
        reg_wr(16'h3030, 64'(f));
        reg_wr(16'h3038, 64'(l));
        push_range(f, l);
        reg_wr(16'h3800, 64'h11);
        chk(busy == 1'b1, "R3", {"busy after start ", tag}, 64'(busy), 64'd1);
        chk(err == 1'b0, "R11", "err cleared on start", 64'(err), 64'd0);
        wait_done(n);
        chk(exp_q.size() == 0, "R6", {"all bursts seen ", tag}, 64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0 && err == 0 && done == 0, "R1", "status after reset", {61'd0, busy, err, done}, 64'd0);
        chk(wr_req_valid == 0 && wr_beat_valid == 0, "R1", "no traffic after reset", {62'd0, wr_req_valid, wr_beat_valid}, 64'd0);
        chk_rd(16'h3030, 64'd0, "R1");
        chk_rd(16'h1740, 64'd0, "R1");

        // R2 readback of every storage location
        reg_wr(16'h3008, 64'hDEAD_BEEF_0000_3008);
        reg_wr(16'h3018, 64'h1234_5678_9ABC_DEF0);
        reg_wr(16'h4000, 64'hFFFF_0000_FFFF_0000);
        for (int k = 0; k < 16; k++) reg_wr(16'h1700 + 16'(k * 8), 64'hA5A5_0000_0000_0000 + 64'(k));
        reg_wr(16'h3010, 64'h5555);
        chk_rd(16'h3008, 64'hDEAD_BEEF_0000_3008, "R2");
        chk_rd(16'h3018, 64'h1234_5678_9ABC_DEF0, "R2");
        chk_rd(16'h4000, 64'hFFFF_0000_FFFF_0000, "R2");
        for (int k = 0; k < 16; k++) chk_rd(16'h1700 + 16'(k * 8), 64'hA5A5_0000_0000_0000 + 64'(k), "R2");
        chk_rd(16'h3010, 64'd0, "R2");
        reg_wr(16'h3030, 64'h0000_00AB_CDEF_0123);
        chk_rd(16'h3030, 64'h0000_00AB_CDEF_0123, "R2");

        // R4 unknown code: error, no burst
        reg_wr(16'h3800, 64'h22);
        chk(err == 1'b1, "R4", "err on unknown code", 64'(err), 64'd1);
        repeat (20) @(negedge clk);
        chk(busy == 1'b0, "R4", "no fill on unknown code", 64'(busy), 64'd0);
        chk_rd(16'h3800, 64'h22, "R4");

        // R10 reversed range
        reg_wr(16'h3030, 64'h5000);
        reg_wr(16'h3038, 64'h4FFF);
        reg_wr(16'h3800, 64'h11);
        chk(err == 1'b1 && busy == 1'b0, "R10", "reversed range refused", {62'd0, err, busy}, 64'd2);
        repeat (20) @(negedge clk);
        chk(done_cnt == 0, "R10", "no completion on refused range", 64'(done_cnt), 64'd0);

        // R3/R5 fills of several shapes
        run_fill(40'h1000, 40'h103F, "aligned");
        run_fill(40'h2003, 40'h200A, "unaligned pair");
        run_fill(40'h3002, 40'h3005, "single beat");
        run_fill(40'h3007, 40'h3007, "single byte");
        // R6 chunking
        run_fill(40'h10005, 40'h10005 + 40'(2 * CHUNK + 99), "three chunks");
        run_fill(40'h20000, 40'h21FFF, "exact two chunks");

        // R9 commands during a fill are ignored
        begin
            int n;
            n = done_cnt + 1;
            reg_wr(16'h3030, 64'h30001);
            reg_wr(16'h3038, 64'h31800);
            push_range(40'h30001, 40'h31800);
            reg_wr(16'h3800, 64'h11);
            repeat (5) @(negedge clk);
            reg_wr(16'h3800, 64'h22);
            chk(err == 1'b0, "R9", "err unchanged by busy command", 64'(err), 64'd0);
            chk_rd(16'h3800, 64'h11, "R9");
            reg_wr(16'h3800, 64'h11);
            wait_done(n);
            repeat (40) @(negedge clk);
            chk(done_cnt == n && busy == 1'b0, "R9", "single completion only", 64'(done_cnt), 64'(n));
            chk(exp_q.size() == 0, "R9", "no extra bursts", 64'(exp_q.size()), 64'd0);
        end

        // R11 error holds until an accepted start
        reg_wr(16'h3800, 64'h7);
        chk(err == 1'b1, "R11", "err set", 64'(err), 64'd1);
        repeat (3) @(negedge clk);
        chk(err == 1'b1, "R11", "err holds", 64'(err), 64'd1);
        run_fill(40'h40010, 40'h4001F, "after error");

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule